// File: doc/BRIEF.md
# Downstream Packet Framer with Acknowledge Generation

This block builds the outgoing packets of a board's serial return link. A packet request carries a pipe number, an integration cycle number, a 32-bit spill number and a payload length. The framer captures these fields when it accepts the request. It then emits a fixed five-word header. The first header word joins the board identity with the pipe number. The next three carry the cycle number and the two halves of the spill number. The fifth carries the word count.

After the header, the framer passes the payload words straight from a payload source. It closes the packet with a 16-bit CRC that covers every word it emitted before the CRC. The output is a 16-bit ready/valid stream, with a flag marking the final word.

A single-cycle acknowledge request from the receive side is remembered. It is answered with an empty packet on the reserved acknowledge pipe. Acknowledges are only inserted between packets. When a data request and an acknowledge are both waiting at a packet boundary, the acknowledge goes first. The serializer downstream and the producer of the payload are outside the block.

Top module: `dn_framer`

## Requirements
- R1: The first word of every packet carries the board identity input in bits 15:4 and the packet's pipe number in bits 3:0.
- R2: The second word carries the integration cycle number in bits 4:0, and bits 15:5 are zero.
- R3: The third word is spill number bits 31:16 and the fourth word is spill number bits 15:0.
- R4: The fifth word equals the number of payload words plus one.
- R5: The payload words follow the header unchanged and in order. Exactly one CRC word follows them, and `out_last` is high with the CRC word only.
- R6: The CRC word is computed as follows: polynomial 0x1021, register seeded with 0xFFFF, each 16-bit word fed most significant bit first, no final inversion, covering all five header words and every payload word.
- R7: An acknowledge packet is six words: the identity word with pipe 15, three zero words, a length word of 1, and the CRC word.
- R8: A pulse on `ack_req` is held pending and answered only after the last word of the packet in flight. While an acknowledge is pending, `req_ready` is low, so a waiting data request goes after the acknowledge.
- R9: The request fields are captured in the cycle where `req_valid` and `req_ready` are both high. Later changes to them do not alter the packet.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value into the next cycle.
- R11: During and straight after reset, `out_valid` is low and `req_ready` is high.
- R12: A request with zero payload length yields a header with length word 1, followed directly by the CRC word.
- R13: A payload word is taken (`pl_valid` and `pl_ready`) only in a cycle where that same word is emitted and accepted at the output. Exactly the requested number of words is taken per packet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| board_id | input | 12 | Board identity, held static |
| ack_req | input | 1 | One-cycle request for an acknowledge packet |
| req_valid | input | 1 | Data packet request present |
| req_ready | output | 1 | Request accepted this cycle when both are high |
| req_pipe | input | 4 | Pipe number of the data packet |
| req_cycle | input | 5 | Integration cycle number |
| req_spill | input | 32 | Spill number |
| req_len | input | 16 | Payload word count (below 65535) |
| pl_valid | input | 1 | Payload word present |
| pl_ready | output | 1 | Payload word taken |
| pl_data | input | 16 | Payload word |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Sink takes the output word |
| out_data | output | 16 | Output word |
| out_last | output | 1 | Output word is the CRC word ending the packet |

## Verification
The hold-while-stalled assertion relies on the payload source. Once the source raises `pl_valid`, it must keep the word and the valid until the word is taken. Otherwise a stall inside the payload could show a changing output. The bench's payload driver inserts idle gaps only before a word is offered, and it never withdraws an offered word. Requests keep `req_len` below 65535, and `board_id` is held constant for the whole run. The bench changes the request fields only after acceptance, which exercises the capture rule.

// File: rtl/dnf_pkg.sv
package dnf_pkg;
  localparam int unsigned WORD_W    = 16;
  localparam int unsigned PIPE_W    = 4;
  localparam int unsigned ID_W      = WORD_W - PIPE_W;
  localparam int unsigned CYC_W     = 5;
  localparam int unsigned SPILL_W   = 2 * WORD_W;
  localparam int unsigned HDR_WORDS = 5;
  localparam int unsigned IDX_W     = $clog2(HDR_WORDS);

  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_PAY, ST_CRC} dnf_state_e;

  // One word through a left-shifting CRC register, MSB of the word first.
  function automatic logic [WORD_W-1:0] crc_next(input logic [WORD_W-1:0] c,
                                                 input logic [WORD_W-1:0] d,
                                                 input logic [WORD_W-1:0] poly);
    logic [WORD_W-1:0] r;
    r = c;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      r = {r[WORD_W-2:0], 1'b0} ^ ((r[WORD_W-1] ^ d[i]) ? poly : '0);
    end
    return r;
  endfunction
endpackage

// File: rtl/dnf_crc.sv
module dnf_crc
  import dnf_pkg::*;
#(
  parameter logic [WORD_W-1:0] POLY = 16'h1021,
  parameter logic [WORD_W-1:0] SEED = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              upd,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] crc
);
  logic [WORD_W-1:0] crc_q, crc_d;
  logic              crc_en;

  always_comb begin
    crc_en = clear | upd;
    crc_d  = clear ? SEED : crc_next(crc_q, word, POLY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= SEED;
    else if (crc_en) crc_q <= crc_d;
  end

  assign crc = crc_q;
endmodule

// File: rtl/dnf_seq.sv
module dnf_seq
  import dnf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack_req,
  input  logic              req_valid,
  input  logic [WORD_W-1:0] req_len,
  input  logic              pl_valid,
  input  logic              out_ready,
  output logic              req_ready,
  output logic              pl_ready,
  output logic              out_valid,
  output logic              out_last,
  output logic              word_fire,
  output logic              start_dat,
  output logic              start_ack,
  output dnf_state_e        st,
  output logic [IDX_W-1:0]  hdr_idx,
  output logic [WORD_W-1:0] len
);
  dnf_state_e        st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [WORD_W-1:0] cnt_q, cnt_d, len_q, len_d, cnt_inc;
  logic              ack_q, ack_d, pend_q, pend_d, ctl_en;

  always_comb begin
    start_ack = (st_q == ST_IDLE) && pend_q;
    start_dat = (st_q == ST_IDLE) && !pend_q && req_valid;
    req_ready = (st_q == ST_IDLE) && !pend_q;
    out_valid = (st_q == ST_HDR) || (st_q == ST_CRC) || ((st_q == ST_PAY) && pl_valid);
    word_fire = out_valid && out_ready;
    pl_ready  = (st_q == ST_PAY) && out_ready;
    out_last  = (st_q == ST_CRC);
    cnt_inc   = cnt_q + 1'b1;
    ctl_en    = start_ack | start_dat | word_fire;
    pend_d    = ack_req | (pend_q & ~start_ack);
  end

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    cnt_d = cnt_q;
    len_d = len_q;
    ack_d = ack_q;
    unique case (st_q)
      ST_IDLE: if (start_ack || start_dat) begin
        st_d  = ST_HDR;
        idx_d = '0;
        ack_d = start_ack;
        len_d = start_ack ? '0 : req_len;
      end
      ST_HDR: if (word_fire) begin
        if (idx_q == IDX_W'(HDR_WORDS - 1)) begin
          st_d  = (len_q == '0) ? ST_CRC : ST_PAY;
          cnt_d = '0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      ST_PAY: if (word_fire) begin
        cnt_d = cnt_inc;
        if (cnt_inc == len_q) st_d = ST_CRC;
      end
      ST_CRC: if (word_fire) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
      cnt_q <= '0;
      len_q <= '0;
      ack_q <= 1'b0;
    end else if (ctl_en) begin
      st_q  <= st_d;
      idx_q <= idx_d;
      cnt_q <= cnt_d;
      len_q <= len_d;
      ack_q <= ack_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign st      = st_q;
  assign hdr_idx = idx_q;
  assign len     = len_q;

  AST_ACK_REMEMBERED: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |=> (pend_q || st_q != ST_IDLE)); // R8
  AST_REQ_STARTS_HDR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (st_q == ST_HDR && idx_q == '0 && !ack_q)); // R9
  AST_LAST_ENDS_PKT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (st_q == ST_IDLE)); // R5
  AST_ACK_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE && ack_q) |-> (len_q == '0)); // R7
endmodule

// File: rtl/dnf_word.sv
module dnf_word
  import dnf_pkg::*;
#(
  parameter logic [PIPE_W-1:0] ACK_PIPE = 4'hF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_dat,
  input  logic               start_ack,
  input  logic [PIPE_W-1:0]  req_pipe,
  input  logic [CYC_W-1:0]   req_cycle,
  input  logic [SPILL_W-1:0] req_spill,
  input  logic [ID_W-1:0]    board_id,
  input  dnf_state_e         st,
  input  logic [IDX_W-1:0]   hdr_idx,
  input  logic [WORD_W-1:0]  len,
  input  logic [WORD_W-1:0]  pl_data,
  input  logic [WORD_W-1:0]  crc,
  output logic [WORD_W-1:0]  out_data
);
  logic [PIPE_W-1:0]  pipe_q, pipe_d;
  logic [CYC_W-1:0]   cyc_q, cyc_d;
  logic [SPILL_W-1:0] spill_q, spill_d;
  logic               fld_en;

  always_comb begin
    fld_en  = start_dat | start_ack;
    pipe_d  = start_ack ? ACK_PIPE : req_pipe;
    cyc_d   = start_ack ? '0 : req_cycle;
    spill_d = start_ack ? '0 : req_spill;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q  <= '0;
      cyc_q   <= '0;
      spill_q <= '0;
    end else if (fld_en) begin
      pipe_q  <= pipe_d;
      cyc_q   <= cyc_d;
      spill_q <= spill_d;
    end
  end

  always_comb begin
    out_data = '0;
    unique case (st)
      ST_HDR: begin
        unique case (hdr_idx)
          IDX_W'(0): out_data = {board_id, pipe_q};
          IDX_W'(1): out_data = {{(WORD_W-CYC_W){1'b0}}, cyc_q};
          IDX_W'(2): out_data = spill_q[SPILL_W-1:WORD_W];
          IDX_W'(3): out_data = spill_q[WORD_W-1:0];
          default:   out_data = len + 1'b1;
        endcase
      end
      ST_PAY:  out_data = pl_data;
      ST_CRC:  out_data = crc;
      default: out_data = '0;
    endcase
  end
endmodule

// File: rtl/dn_framer.sv
module dn_framer
  import dnf_pkg::*;
#(
  parameter logic [PIPE_W-1:0] ACK_PIPE = 4'hF,
  parameter logic [WORD_W-1:0] CRC_POLY = 16'h1021,
  parameter logic [WORD_W-1:0] CRC_SEED = 16'hFFFF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ID_W-1:0]    board_id,
  input  logic               ack_req,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [PIPE_W-1:0]  req_pipe,
  input  logic [CYC_W-1:0]   req_cycle,
  input  logic [SPILL_W-1:0] req_spill,
  input  logic [WORD_W-1:0]  req_len,
  input  logic               pl_valid,
  output logic               pl_ready,
  input  logic [WORD_W-1:0]  pl_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [WORD_W-1:0]  out_data,
  output logic               out_last
);
  dnf_state_e        st;
  logic [IDX_W-1:0]  hdr_idx;
  logic [WORD_W-1:0] len, crc;
  logic              word_fire, start_dat, start_ack, crc_upd;

  dnf_seq u_seq (
    .clk, .rst_n, .ack_req, .req_valid, .req_len, .pl_valid, .out_ready,
    .req_ready, .pl_ready, .out_valid, .out_last, .word_fire,
    .start_dat, .start_ack, .st, .hdr_idx, .len
  );

  assign crc_upd = word_fire && (st != ST_CRC);

  dnf_crc #(.POLY(CRC_POLY), .SEED(CRC_SEED)) u_crc (
    .clk, .rst_n, .clear(start_dat | start_ack), .upd(crc_upd),
    .word(out_data), .crc
  );

  dnf_word #(.ACK_PIPE(ACK_PIPE)) u_word (
    .clk, .rst_n, .start_dat, .start_ack, .req_pipe, .req_cycle, .req_spill,
    .board_id, .st, .hdr_idx, .len, .pl_data, .crc, .out_data
  );

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R10
  AST_CRC_SEEDED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HDR && hdr_idx == '0) |-> (crc == CRC_SEED)); // R6
  AST_PL_TAKEN_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_valid && pl_ready) |-> (out_valid && out_ready && out_data == pl_data)); // R13
endmodule

// File: tb/dn_framer_bench.sv
`timescale 1ns/1ps
module dn_framer_bench;
  localparam logic [11:0] BID = 12'hA5C;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ack_req, req_valid, req_ready, pl_valid, pl_ready;
  logic        out_valid, out_ready, out_last;
  logic [3:0]  req_pipe;
  logic [4:0]  req_cycle;
  logic [31:0] req_spill;
  logic [15:0] req_len, pl_data, out_data;

  always #2 clk = ~clk;

  dn_framer u_dn_framer (
    .clk, .rst_n, .board_id(BID), .ack_req, .req_valid, .req_ready,
    .req_pipe, .req_cycle, .req_spill, .req_len, .pl_valid, .pl_ready,
    .pl_data, .out_valid, .out_ready, .out_data, .out_last
  );

  typedef struct { logic [15:0] d; logic l; string t; } exp_t;
  exp_t        exp_q[$];
  logic [15:0] pl_q[$];
  int          vectors = 0, errs = 0;
  bit          bp = 0, gaps = 0, finished = 0;
  bit          fire_req = 0, pl_hold = 0, prev_stall = 0;
  logic [15:0] prev_data = '0;

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_w(input logic [15:0] c, input logic [15:0] d);
    logic [15:0] r = c;
    for (int i = 15; i >= 0; i--) begin
      if (r[15] ^ d[i]) r = (r << 1) ^ 16'h1021;
      else              r = r << 1;
    end
    return r;
  endfunction

  function automatic void push(input logic [15:0] d, input logic l, input string t);
    exp_t e;
    e.d = d; e.l = l; e.t = t;
    exp_q.push_back(e);
  endfunction

  // Scoreboard driver: queue expected words, then offer the request.
  task automatic send_data(input logic [3:0] pipe, input logic [4:0] cyc,
                           input logic [31:0] spill, input int n, input string tg);
    logic [15:0] h[5];
    logic [15:0] c = 16'hFFFF;
    h[0] = {BID, pipe}; h[1] = {11'd0, cyc}; h[2] = spill[31:16];
    h[3] = spill[15:0]; h[4] = 16'(n + 1);
    for (int k = 0; k < 5; k++) begin
      c = crc_w(c, h[k]);
      push(h[k], 1'b0, tg != "" ? tg : (k == 0 ? "R1" : k == 1 ? "R2" : k == 4 ? (n == 0 ? "R12" : "R4") : "R3"));
    end
    for (int k = 0; k < n; k++) begin
      logic [15:0] w = 16'(pipe * 16'h1000) ^ 16'(k * 16'h0137) ^ spill[15:0];
      pl_q.push_back(w);
      c = crc_w(c, w);
      push(w, 1'b0, "R5");
    end
    push(c, 1'b1, n == 0 ? "R12" : "R6");
    @(negedge clk);
    req_valid = 1'b1; req_pipe = pipe; req_cycle = cyc; req_spill = spill; req_len = 16'(n);
    do @(posedge clk); while (!fire_req);
    @(negedge clk);
    req_valid = 1'b0; req_pipe = ~pipe; req_cycle = ~cyc; req_spill = ~spill; req_len = 16'hBEEF;
  endtask

  task automatic send_ack(input string tg);
    logic [15:0] h[5];
    logic [15:0] c = 16'hFFFF;
    h[0] = {BID, 4'hF}; h[1] = '0; h[2] = '0; h[3] = '0; h[4] = 16'd1;
    for (int k = 0; k < 5; k++) begin
      c = crc_w(c, h[k]);
      push(h[k], 1'b0, tg);
    end
    push(c, 1'b1, tg);
    @(negedge clk); ack_req = 1'b1;
    @(negedge clk); ack_req = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // Payload source, sink and output monitor; samples 1 ns after the falling edge.
  initial begin
    pl_valid = 1'b0; pl_data = '0; out_ready = 1'b1;
    forever begin
      @(negedge clk);
      if (!pl_hold) begin
        if (pl_q.size() > 0 && (!gaps || ($urandom % 4) != 0)) begin
          pl_valid = 1'b1; pl_data = pl_q[0];
        end else pl_valid = 1'b0;
      end
      out_ready = bp ? (($urandom % 3) != 0) : 1'b1;
      #1;
      if (rst_n) begin
        bit fo, fp;
        exp_t e;
        if (prev_stall) chk(out_valid && out_data == prev_data, "R10", {15'd0, out_valid, out_data}, {16'd1, prev_data});
        fo = out_valid && out_ready;
        fp = pl_valid && pl_ready;
        fire_req = req_valid && req_ready;
        if (fp) begin
          chk(fo && out_data == pl_data, "R13", {15'd0, fo, out_data}, {16'd1, pl_data});
          void'(pl_q.pop_front());
        end
        if (fo) begin
          if (exp_q.size() == 0) chk(1'b0, "R5", {15'd0, out_last, out_data}, 32'hFFFFFFFF);
          else begin
            e = exp_q.pop_front();
            chk(out_data == e.d && out_last == e.l, e.t, {15'd0, out_last, out_data}, {15'd0, e.l, e.d});
          end
        end
        prev_stall = out_valid && !out_ready;
        prev_data  = out_data;
        pl_hold    = pl_valid && !fp;
      end
    end
  end

  initial begin
    rst_n = 1'b0; ack_req = 1'b0; req_valid = 1'b0;
    req_pipe = '0; req_cycle = '0; req_spill = '0; req_len = '0;
    repeat (4) @(negedge clk);
    #1 chk(out_valid == 1'b0, "R11", {31'd0, out_valid}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    #1 chk(out_valid == 1'b0 && req_ready == 1'b1, "R11", {30'd0, out_valid, req_ready}, 32'd1);
    fork
      begin
        send_data(4'd2, 5'd17, 32'h1234_5678, 4, "");            // R1 R2 R3 R4 R5 R6
        drain();
        send_data(4'd4, 5'd3, 32'hCAFE_0001, 0, "");             // R12 zero payload
        drain();
        send_ack("R7");                                          // R7 idle acknowledge
        drain();
        bp = 1; gaps = 1;
        send_data(4'd12, 5'd31, 32'h0F0F_A0A0, 20, "");          // R10 stalls, R13 gaps
        drain();
        send_data(4'd1, 5'd9, 32'h8000_0001, 8, "R9");           // R9 fields scrambled after accept
        repeat (3) @(negedge clk);
        send_ack("R8");                                          // R8 deferred, beats waiting request
        send_data(4'd2, 5'd0, 32'hFFFF_FFFF, 2, "R8");
        drain();
        bp = 0; gaps = 0;
        send_data(4'd12, 5'd1, 32'h0000_0000, 1, "");
        drain();
        finished = 1;
      end
      begin
        repeat (100000) @(posedge clk);
      end
    join_any
    disable fork;
    if (!finished) chk(1'b0, "watchdog", 32'd0, 32'd1);
    chk(pl_q.size() == 0, "R13", pl_q.size(), 32'd0);
    chk(exp_q.size() == 0, "R5", exp_q.size(), 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule